// File: doc/BRIEF.md
# Dual-Lane Parallel Flash Erase Sequencer

This block drives two byte-wide flash devices that share one 16-bit data path and erases them together. A single start pulse erases every address from zero up to a given end address. Each erase loop issues a two-word erase sequence, waits a programmable erase time, then issues a verify word carrying the current address. After a short settle time it reads the word back. Each byte lane is judged on its own: a lane counts as erased at an address when its byte reads all-ones.

A lane that has already verified at the current address receives the all-ones (reset) byte in every later command word. It therefore takes no further erase pulses and is not over-erased while the other lane catches up. When both lanes pass, the lane mask clears and the address advances. The next verify word goes out at once, with no new erase. When the end address passes, a reset word ends the run and `done_o` is raised. If one address needs more erase loops than a parameterised limit, the run stops with `error_o`.

Top module: `par_erase_ctrl`

## Requirements
- R1: After reset, `wr_en_o`, `rd_en_o`, `done_o` and `error_o` are 0 and `addr_o` is 0.
- R2: A start pulse begins a run at address 0. The first two strobes are write strobes in consecutive cycles. Each carries the erase word, in which every lane that has not verified holds 20h. At start this word is 2020h.
- R3: The verify write comes exactly ERASE_CYC+1 cycles after the second erase write. In the verify word each pending lane holds A0h, and `addr_o` equals the current address.
- R4: A read strobe comes exactly VFY_CYC+1 cycles after each verify write, at the same address. A lane passes when its byte of `rd_data_i` equals FFh. The low lane is bits 7:0 and the high lane is bits 15:8.
- R5: When either lane fails, the sequence restarts with the two erase writes at the same address.
- R6: A lane that has passed at the current address carries FFh in every following erase and verify word. For example, 20FFh and A0FFh are sent when only the low lane has passed.
- R7: When both lanes pass at an address below the end address, the lane mask clears and the address rises by one. The next strobe is a verify write of A0A0h with no erase before it.
- R8: When both lanes pass at the end address, the block writes FFFFh and then holds `done_o` high with no strobes until the next start.
- R9: Each address allows at most MAX_LOOPS erase loops. A failed read after the last allowed loop raises `error_o`, which stays high with no strobes until the next start.
- R10: A write strobe and a read strobe are never active in the same cycle, and `done_o` and `error_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a run (accepted when idle, done or in error) |
| end_addr_i | input | AW | Last address to verify, latched at start |
| rd_data_i | input | 16 | Read data from both devices, valid during the read strobe |
| wr_en_o | output | 1 | Command write strobe |
| rd_en_o | output | 1 | Read strobe |
| addr_o | output | AW | Current address |
| wr_data_o | output | 16 | Command word, one byte per lane |
| done_o | output | 1 | Run completed |
| error_o | output | 1 | Loop limit exceeded |

## Verification
The hardest case to reach from the ports is one lane verifying while the other still needs several more pulses. After that, the masked command words must appear and the erase count must stop growing for the passed lane only. The bench drives this with a behavioural dual-device model. For each address and lane, the model holds the number of erase pulses needed before the lane reads FFh. It counts pulses per lane from the 20h-20h byte pairs it actually receives. The lane requirements are set to differ in both directions, so low-lane-first and high-lane-first masking both occur. A high-lane requirement above the loop limit drives the error path.

// File: rtl/par_erase_pkg.sv
package par_erase_pkg;

    localparam logic [7:0] CMD_ERASE  = 8'h20;
    localparam logic [7:0] CMD_VERIFY = 8'hA0;
    localparam logic [7:0] CMD_RESET  = 8'hFF;
    localparam logic [7:0] LANE_OK    = 8'hFF;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ERASE_A,
        ST_ERASE_B,
        ST_ERASE_WAIT,
        ST_VFY_CMD,
        ST_VFY_WAIT,
        ST_SAMPLE,
        ST_RESET_CMD,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_ERASE,
        OP_VERIFY,
        OP_RESET
    } cmd_op_e;

endpackage

// File: rtl/pe_word_build.sv
module pe_word_build
    import par_erase_pkg::*;
#(
    parameter int LANES = 2
) (
    input  cmd_op_e              op_i,
    input  logic [LANES-1:0]     mask_i,
    output logic [8*LANES-1:0]   word_o
);

    logic [7:0] base_byte;

    always_comb begin
        case (op_i)
            OP_ERASE:  base_byte = CMD_ERASE;
            OP_VERIFY: base_byte = CMD_VERIFY;
            default:   base_byte = CMD_RESET;
        endcase
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[8*g +: 8] = mask_i[g] ? CMD_RESET : base_byte;
    end

endmodule

// File: rtl/pe_lane_check.sv
module pe_lane_check
    import par_erase_pkg::*;
#(
    parameter int LANES = 2
) (
    input  logic [8*LANES-1:0] rd_data_i,
    input  logic [LANES-1:0]   mask_i,
    output logic [LANES-1:0]   pass_o,
    output logic               all_pass_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pass_o[g] = mask_i[g] | (rd_data_i[8*g +: 8] == LANE_OK);
    end

    assign all_pass_o = &pass_o;

endmodule

// File: rtl/pe_countdown.sv
module pe_countdown #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [TW-1:0] load_val_i,
    output logic          zero_o
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/par_erase_ctrl.sv
module par_erase_ctrl
    import par_erase_pkg::*;
#(
    parameter int AW        = 8,
    parameter int ERASE_CYC = 40,
    parameter int VFY_CYC   = 3,
    parameter int MAX_LOOPS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] end_addr_i,
    input  logic [15:0]   rd_data_i,
    output logic          wr_en_o,
    output logic          rd_en_o,
    output logic [AW-1:0] addr_o,
    output logic [15:0]   wr_data_o,
    output logic          done_o,
    output logic          error_o
);

    localparam int LANES   = 2;
    localparam int DW      = 8 * LANES;
    localparam int MAX_CYC = (ERASE_CYC > VFY_CYC) ? ERASE_CYC : VFY_CYC;
    localparam int TW      = $clog2(MAX_CYC + 1);
    localparam int LW      = $clog2(MAX_LOOPS + 1);

    typedef struct packed {
        seq_state_e      st;
        logic [AW-1:0]   addr;
        logic [AW-1:0]   last;
        logic [LANES-1:0] mask;
        logic [LW-1:0]   loops;
    } seq_regs_t;

    seq_regs_t r_d, r_q;

    logic            tmr_load;
    logic [TW-1:0]   tmr_val;
    logic            tmr_zero;
    cmd_op_e         op;
    logic [LANES-1:0] pass_vec;
    logic            all_pass;
    logic [DW-1:0]   word;
    logic            wr_en, rd_en;

    pe_countdown #(.TW(TW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    pe_word_build #(.LANES(LANES)) u_word (
        .op_i   (op),
        .mask_i (r_q.mask),
        .word_o (word)
    );

    pe_lane_check #(.LANES(LANES)) u_check (
        .rd_data_i  (rd_data_i),
        .mask_i     (r_q.mask),
        .pass_o     (pass_vec),
        .all_pass_o (all_pass)
    );

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        op       = OP_ERASE;
        case (r_q.st)
            ST_IDLE, ST_DONE, ST_FAULT: begin
                if (start_i) begin
                    r_d.st    = ST_ERASE_A;
                    r_d.addr  = '0;
                    r_d.last  = end_addr_i;
                    r_d.mask  = '0;
                    r_d.loops = LW'(1);
                end
            end
            ST_ERASE_A: begin
                wr_en  = 1'b1;
                op     = OP_ERASE;
                r_d.st = ST_ERASE_B;
            end
            ST_ERASE_B: begin
                wr_en    = 1'b1;
                op       = OP_ERASE;
                tmr_load = 1'b1;
                tmr_val  = TW'(ERASE_CYC - 1);
                r_d.st   = ST_ERASE_WAIT;
            end
            ST_ERASE_WAIT: begin
                if (tmr_zero) r_d.st = ST_VFY_CMD;
            end
            ST_VFY_CMD: begin
                wr_en    = 1'b1;
                op       = OP_VERIFY;
                tmr_load = 1'b1;
                tmr_val  = TW'(VFY_CYC - 1);
                r_d.st   = ST_VFY_WAIT;
            end
            ST_VFY_WAIT: begin
                if (tmr_zero) r_d.st = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                rd_en = 1'b1;
                if (all_pass) begin
                    if (r_q.addr == r_q.last) begin
                        r_d.st = ST_RESET_CMD;
                    end else begin
                        r_d.addr  = r_q.addr + 1'b1;
                        r_d.mask  = '0;
                        r_d.loops = '0;
                        r_d.st    = ST_VFY_CMD;
                    end
                end else begin
                    r_d.mask = pass_vec;
                    if (r_q.loops >= LW'(MAX_LOOPS)) begin
                        r_d.st = ST_FAULT;
                    end else begin
                        r_d.loops = r_q.loops + 1'b1;
                        r_d.st    = ST_ERASE_A;
                    end
                end
            end
            ST_RESET_CMD: begin
                wr_en  = 1'b1;
                op     = OP_RESET;
                r_d.st = ST_DONE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.addr  <= '0;
            r_q.last  <= '0;
            r_q.mask  <= '0;
            r_q.loops <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign wr_en_o   = wr_en;
    assign rd_en_o   = rd_en;
    assign addr_o    = r_q.addr;
    assign wr_data_o = wr_en ? word : '0;
    assign done_o    = (r_q.st == ST_DONE);
    assign error_o   = (r_q.st == ST_FAULT);

endmodule

// File: rtl/par_erase_checks.sv
module par_erase_checks #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          wr_en_o,
    input logic          rd_en_o,
    input logic [AW-1:0] addr_o,
    input logic [15:0]   wr_data_o,
    input logic          done_o,
    input logic          error_o
);

    p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_en_o));

    p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));

    p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!wr_en_o && !rd_en_o));

    p_done_after_reset_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(wr_en_o && wr_data_o == 16'hFFFF));

    p_error_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> (!wr_en_o && !rd_en_o));

    p_error_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> $past(rd_en_o));

    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(addr_o) |-> (addr_o == $past(addr_o) + 1'b1 || addr_o == '0));

    p_read_after_verify_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && wr_data_o[7:0] == 8'hA0) |=> !wr_en_o);

endmodule

bind par_erase_ctrl par_erase_checks #(.AW(AW)) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .wr_en_o   (wr_en_o),
    .rd_en_o   (rd_en_o),
    .addr_o    (addr_o),
    .wr_data_o (wr_data_o),
    .done_o    (done_o),
    .error_o   (error_o)
);

// File: tb/par_erase_ctrl_test.sv
module par_erase_ctrl_test;

    localparam int AW        = 4;
    localparam int ERASE_CYC = 12;
    localparam int VFY_CYC   = 3;
    localparam int MAX_LOOPS = 4;
    localparam int NADDR     = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] end_addr_i = '0;
    logic [15:0]   rd_data_i;
    logic          wr_en_o, rd_en_o, done_o, error_o;
    logic [AW-1:0] addr_o;
    logic [15:0]   wr_data_o;

    always #2 clk = ~clk;   // 250 MHz

    par_erase_ctrl #(
        .AW(AW), .ERASE_CYC(ERASE_CYC), .VFY_CYC(VFY_CYC), .MAX_LOOPS(MAX_LOOPS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .end_addr_i(end_addr_i),
        .rd_data_i(rd_data_i), .wr_en_o(wr_en_o), .rd_en_o(rd_en_o),
        .addr_o(addr_o), .wr_data_o(wr_data_o), .done_o(done_o), .error_o(error_o)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    // device model: pulses needed per address and lane, pulses received per lane
    int need [NADDR][2];
    int got  [2];
    logic [15:0] prev_wr;
    int vaddr;

    // expected write stream
    logic [15:0] exp_data [$];
    int          exp_addr [$];
    int          exp_kind [$];   // 0 erase, 1 verify, 2 reset
    bit          monitor = 1'b0;
    int          erase_first_cyc, erase_second_cyc, vfy_cyc;
    bit          erase_half;

    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int l = 0; l < 2; l++)
            rd_data_i[8*l +: 8] = (got[l] >= need[vaddr][l]) ? 8'hFF : 8'h00;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // per-clock comparison against the expected stream
    always @(negedge clk) begin
        if (monitor) begin
            chk(!(wr_en_o && rd_en_o), "R10", "strobe overlap", {wr_en_o, rd_en_o}, 0);
            chk(!(done_o && error_o), "R10", "flag overlap", {done_o, error_o}, 0);
            if (rd_en_o) begin
                chk(cyc == vfy_cyc + VFY_CYC + 1, "R4", "read timing", cyc, vfy_cyc + VFY_CYC + 1);
                chk(int'(addr_o) == vaddr, "R4", "read address", addr_o, vaddr);
            end
            if (wr_en_o) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R8", "unexpected write", wr_data_o, 0);
                end else begin
                    automatic logic [15:0] ed = exp_data.pop_front();
                    automatic int ea = exp_addr.pop_front();
                    automatic int ek = exp_kind.pop_front();
                    chk(wr_data_o == ed, (ek == 0) ? "R6" : (ek == 1) ? "R7" : "R8",
                        "command word", wr_data_o, ed);
                    if (ea >= 0) chk(int'(addr_o) == ea, "R3", "verify address", addr_o, ea);
                    if (ek == 0) begin
                        if (!erase_half) erase_first_cyc = cyc;
                        else begin
                            erase_second_cyc = cyc;
                            chk(cyc == erase_first_cyc + 1, "R2", "erase pair back-to-back",
                                cyc, erase_first_cyc + 1);
                        end
                        erase_half = !erase_half;
                    end else if (ek == 1) begin
                        vfy_cyc = cyc;
                    end
                end
                for (int l = 0; l < 2; l++) begin
                    if (wr_data_o[8*l +: 8] == 8'h20 && prev_wr[8*l +: 8] == 8'h20) got[l]++;
                end
                if (wr_data_o[7:0] == 8'hA0 || wr_data_o[15:8] == 8'hA0) vaddr = int'(addr_o);
                prev_wr = wr_data_o;
            end
        end
    end

    // behavioural expectation; returns 1 for done, 0 for error
    function automatic bit build_expect(input int last);
        int p[2];
        bit m[2];
        bit pass[2];
        int a, loops;
        p[0] = 0; p[1] = 0; m[0] = 0; m[1] = 0; a = 0; loops = 1;
        for (int k = 0; k < 2; k++) begin
            exp_data.push_back(16'h2020); exp_addr.push_back(-1); exp_kind.push_back(0);
        end
        p[0]++; p[1]++;
        forever begin
            exp_data.push_back({m[1] ? 8'hFF : 8'hA0, m[0] ? 8'hFF : 8'hA0});
            exp_addr.push_back(a); exp_kind.push_back(1);
            for (int l = 0; l < 2; l++) pass[l] = m[l] || (p[l] >= need[a][l]);
            if (pass[0] && pass[1]) begin
                if (a == last) begin
                    exp_data.push_back(16'hFFFF); exp_addr.push_back(-1); exp_kind.push_back(2);
                    return 1'b1;
                end
                a++; m[0] = 0; m[1] = 0; loops = 0;
            end else begin
                m[0] = pass[0]; m[1] = pass[1];
                if (loops >= MAX_LOOPS) return 1'b0;
                loops++;
                for (int k = 0; k < 2; k++) begin
                    exp_data.push_back({m[1] ? 8'hFF : 8'h20, m[0] ? 8'hFF : 8'h20});
                    exp_addr.push_back(-1); exp_kind.push_back(0);
                end
                for (int l = 0; l < 2; l++) if (!m[l]) p[l]++;
            end
        end
    endfunction

    task automatic run_case(input string name, input int last);
        bit exp_done;
        int t0;
        exp_data.delete(); exp_addr.delete(); exp_kind.delete();
        got[0] = 0; got[1] = 0; prev_wr = 16'h0; vaddr = 0; erase_half = 0;
        exp_done = build_expect(last);
        @(negedge clk);
        end_addr_i = AW'(last);
        start_i = 1'b1;
        monitor = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        t0 = cyc;
        while (!done_o && !error_o && cyc - t0 < 20000) @(negedge clk);
        chk(done_o == exp_done, exp_done ? "R8" : "R9", {name, " done flag"}, done_o, exp_done);
        chk(error_o == !exp_done, exp_done ? "R8" : "R9", {name, " error flag"}, error_o, !exp_done);
        chk(exp_data.size() == 0, "R5", {name, " writes left over"}, exp_data.size(), 0);
        if (!exp_done)
            chk(got[1] == MAX_LOOPS || got[0] == MAX_LOOPS, "R9", {name, " loop count"},
                got[1] > got[0] ? got[1] : got[0], MAX_LOOPS);
        repeat (6) begin
            @(negedge clk);
            chk(!wr_en_o && !rd_en_o, exp_done ? "R8" : "R9", {name, " quiet after end"},
                {wr_en_o, rd_en_o}, 0);
        end
        chk(done_o == exp_done && error_o == !exp_done, exp_done ? "R8" : "R9",
            {name, " flag held"}, {done_o, error_o}, {exp_done, !exp_done});
        monitor = 1'b0;
    endtask

    task automatic set_all(input int v0, input int v1);
        for (int a = 0; a < NADDR; a++) begin need[a][0] = v0; need[a][1] = v1; end
    endtask

    initial begin
        set_all(1, 1);
        got[0] = 0; got[1] = 0; vaddr = 0; prev_wr = 16'h0;
        repeat (3) @(negedge clk);
        chk(!wr_en_o && !rd_en_o && !done_o && !error_o && addr_o == '0, "R1", "reset state",
            {wr_en_o, rd_en_o, done_o, error_o, 4'(addr_o)}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!wr_en_o && !done_o && !error_o, "R1", "idle after reset", {wr_en_o, done_o, error_o}, 0);

        // R2 R3 R7: every lane passes first time, address walks without re-erase
        set_all(1, 1);
        run_case("walk", 3);

        // R6: low lane passes first, high lane needs more
        set_all(1, 1);
        need[0][0] = 1; need[0][1] = 3;
        run_case("low_first", 1);

        // R5 R6: high lane first, later address needs retries at the same address
        set_all(1, 1);
        need[0][0] = 2; need[0][1] = 1;
        need[2][0] = 3; need[2][1] = 4;
        run_case("high_first", 2);

        // R9: loop limit exceeded
        set_all(1, 1);
        need[0][1] = MAX_LOOPS + 2;
        run_case("limit", 3);

        // R8: single address run restarted from error state
        set_all(1, 1);
        run_case("single", 0);

        // R5: mid-range address needs several loops, end at top address
        set_all(1, 1);
        need[NADDR-1][0] = 2; need[5][1] = 3;
        run_case("top", NADDR - 1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule